// File: doc/BRIEF.md
# Pattern Block Generator

This block produces a repeating framed test stream for exercising downstream signal-processing logic. A small pattern memory, filled beforehand through a plain write port, is played out in bursts: each burst (a block) reads consecutive memory words starting at a configured low address, with the sample flagged valid and the first and last samples marked as start and end of packet. Each burst is followed by a configured number of idle cycles. A typical setting plays 176 interleaved two-polarisation complex samples per block followed by 80 idle cycles. Every block therefore starts 256 cycles after the one before it.

Each block carries a sequence number. It takes an initial value when the generator starts and counts up by one per block. An optional sync marker flags the first sample of every Nth block. Configuration arrives as static register-style inputs. Enable is examined only at block boundaries, so dropping it lets the running block finish.

Top module: `blk_pattern_gen`

## Requirements
- R1: After reset, and for as long as `cfg_enable` stays low, `out_valid`, `out_sop`, `out_eop` and `out_sync` are all 0.
- R2: If `cfg_enable` is first sampled high at rising edge k while the generator is idle, the first sample of the first block is on the outputs right after edge k+1, with `out_sop` = 1.
- R3: A block is `cfg_blk_len` consecutive cycles with `out_valid` = 1. `out_sop` marks its first cycle and `out_eop` its last. A block of length 1 has both flags set on the same cycle.
- R4: Within a block, the sample at position p is the memory word at address `cfg_lo_addr + (p mod (cfg_hi_addr - cfg_lo_addr + 1))`. The read address wraps from the high address back to the low address.
- R5: Exactly `cfg_gap_len` cycles with `out_valid` = 0 separate one block's `out_eop` from the next block's `out_sop`. A gap of 0 gives back-to-back blocks.
- R6: With `cfg_sync_en` = 1, `out_sync` is 1 on the first sample of block number b (counted from 0 since the start) exactly when b mod `cfg_blks_per_sync` = 0. With `cfg_sync_en` = 0 it is never 1.
- R7: `out_bsn` equals `cfg_bsn_init` during the first block after a start, rises by one (modulo 2^BSN_W) with each later block, and stays constant within a block.
- R8: Dropping `cfg_enable` during a block lets that block complete, and no further block follows. Raising it again starts afresh from the low address, the initial sequence number and sync block 0.
- R9: A word written with `wr_en` = 1 at `wr_addr` is the value played out whenever that address is read later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Run the generator; examined at block starts |
| cfg_sync_en | input | 1 | Allow sync markers |
| cfg_blk_len | input | LEN_W | Samples per block (at least 1) |
| cfg_gap_len | input | LEN_W | Idle cycles between blocks |
| cfg_blks_per_sync | input | SYNC_W | Blocks per sync period (at least 1) |
| cfg_lo_addr | input | ADDR_W | First memory address of each block |
| cfg_hi_addr | input | ADDR_W | Last address before wrapping (not below the low address) |
| cfg_bsn_init | input | BSN_W | Sequence number of the first block after a start |
| wr_en | input | 1 | Pattern memory write strobe |
| wr_addr | input | ADDR_W | Pattern memory write address |
| wr_data | input | DATA_W | Pattern memory write data |
| out_data | output | DATA_W | Sample word |
| out_valid | output | 1 | Sample valid |
| out_sop | output | 1 | First sample of a block |
| out_eop | output | 1 | Last sample of a block |
| out_sync | output | 1 | Sync marker on a block's first sample |
| out_bsn | output | BSN_W | Block sequence number |

## Verification
The first sample follows enable by two register stages. The sequencer registers the issue at the edge that sees enable high, and the memory read and the flag alignment land together one edge later. After that, every output is a pure function of the cycle index n counted from that first sample: block n/(len+gap), position n mod (len+gap). The bench raises enable at a falling edge and lets one rising edge pass. It then compares all outputs at every falling edge against that closed-form expectation, so each result is sampled half a cycle after the edge that produces it. Enable is dropped right after the last wanted block has started, and the comparison runs on past the final gap to confirm that nothing more comes out.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic valid;
    logic sop;
    logic eop;
    logic sync;
  } bpg_flags_t;

endpackage

// File: rtl/bpg_pattern_ram.sv
module bpg_pattern_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/bpg_sequencer.sv
module bpg_sequencer
  import bpg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 16,
  parameter int SYNC_W = 16,
  parameter int BSN_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_sync_en,
  input  logic [LEN_W-1:0]  cfg_blk_len,
  input  logic [LEN_W-1:0]  cfg_gap_len,
  input  logic [SYNC_W-1:0] cfg_blks_per_sync,
  input  logic [ADDR_W-1:0] cfg_lo_addr,
  input  logic [ADDR_W-1:0] cfg_hi_addr,
  input  logic [BSN_W-1:0]  cfg_bsn_init,
  output bpg_flags_t        iss_flags,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [BSN_W-1:0]  iss_bsn
);
  seq_state_t        state_q, state_d;
  bpg_flags_t        flags_d;
  logic [ADDR_W-1:0] addr_d;
  logic [BSN_W-1:0]  bsn_d;
  logic [LEN_W-1:0]  samp_q, samp_d, gap_q, gap_d;
  logic [SYNC_W-1:0] idx_q, idx_d, cur_idx;
  logic              do_start, fresh, blk_done, gap_done;

  assign blk_done = samp_q >= cfg_blk_len;
  assign gap_done = gap_q >= cfg_gap_len;

  always_comb begin
    do_start = 1'b0;
    fresh    = 1'b0;
    state_d  = state_q;
    samp_d   = samp_q;
    gap_d    = gap_q;
    idx_d    = idx_q;
    addr_d   = iss_addr;
    bsn_d    = iss_bsn;
    flags_d  = '0;
    case (state_q)
      ST_IDLE: begin
        do_start = cfg_enable;
        fresh    = 1'b1;
      end
      ST_BURST: begin
        if (blk_done) begin
          if (cfg_gap_len == '0) begin
            do_start = cfg_enable;
            if (!cfg_enable) state_d = ST_IDLE;
          end else begin
            state_d = ST_GAP;
            gap_d   = LEN_W'(1);
          end
        end else begin
          flags_d.valid = 1'b1;
          flags_d.eop   = (samp_q + LEN_W'(1)) >= cfg_blk_len;
          samp_d        = samp_q + LEN_W'(1);
          addr_d        = (iss_addr == cfg_hi_addr) ? cfg_lo_addr : iss_addr + ADDR_W'(1);
        end
      end
      ST_GAP: begin
        if (gap_done) begin
          do_start = cfg_enable;
          if (!cfg_enable) state_d = ST_IDLE;
        end else begin
          gap_d = gap_q + LEN_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase

    cur_idx = fresh ? '0 : idx_q;
    if (do_start) begin
      state_d       = ST_BURST;
      flags_d.valid = 1'b1;
      flags_d.sop   = 1'b1;
      flags_d.eop   = cfg_blk_len <= LEN_W'(1);
      flags_d.sync  = cfg_sync_en && (cur_idx == '0);
      addr_d        = cfg_lo_addr;
      samp_d        = LEN_W'(1);
      bsn_d         = fresh ? cfg_bsn_init : iss_bsn + BSN_W'(1);
      idx_d         = ((cur_idx + SYNC_W'(1)) >= cfg_blks_per_sync) ? '0 : cur_idx + SYNC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      iss_flags <= '0;
      iss_addr  <= '0;
      iss_bsn   <= '0;
      samp_q    <= '0;
      gap_q     <= '0;
      idx_q     <= '0;
    end else begin
      state_q   <= state_d;
      iss_flags <= flags_d;
      iss_addr  <= addr_d;
      iss_bsn   <= bsn_d;
      samp_q    <= samp_d;
      gap_q     <= gap_d;
      idx_q     <= idx_d;
    end
  end

  // R3
  block_contiguous_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_flags.valid && !iss_flags.sop) |-> ($past(iss_flags.valid) && !$past(iss_flags.eop)));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_flags.valid && !iss_flags.sop) |->
      ((iss_addr == ADDR_W'($past(iss_addr) + ADDR_W'(1))) || ($past(iss_addr) == $past(cfg_hi_addr))));

  // R6
  sync_gated_chk: assert property (@(posedge clk) disable iff (rst)
    iss_flags.sync |-> $past(cfg_sync_en));

  // R7
  bsn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_flags.valid && !iss_flags.sop) |-> $stable(iss_bsn));
endmodule

// File: rtl/bpg_align.sv
module bpg_align
  import bpg_pkg::*;
#(
  parameter int BSN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  bpg_flags_t       in_flags,
  input  logic [BSN_W-1:0] in_bsn,
  output bpg_flags_t       out_flags,
  output logic [BSN_W-1:0] out_bsn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_flags <= '0;
      out_bsn   <= '0;
    end else begin
      out_flags <= in_flags;
      out_bsn   <= in_bsn;
    end
  end
endmodule

// File: rtl/blk_pattern_gen.sv
module blk_pattern_gen
  import bpg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 16,
  parameter int SYNC_W = 16,
  parameter int BSN_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_sync_en,
  input  logic [LEN_W-1:0]  cfg_blk_len,
  input  logic [LEN_W-1:0]  cfg_gap_len,
  input  logic [SYNC_W-1:0] cfg_blks_per_sync,
  input  logic [ADDR_W-1:0] cfg_lo_addr,
  input  logic [ADDR_W-1:0] cfg_hi_addr,
  input  logic [BSN_W-1:0]  cfg_bsn_init,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_sync,
  output logic [BSN_W-1:0]  out_bsn
);
  bpg_flags_t        iss_flags, o_flags;
  logic [ADDR_W-1:0] iss_addr;
  logic [BSN_W-1:0]  iss_bsn;

  bpg_sequencer #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SYNC_W(SYNC_W), .BSN_W(BSN_W)
  ) u_seq (
    .clk              (clk),
    .rst              (rst),
    .cfg_enable       (cfg_enable),
    .cfg_sync_en      (cfg_sync_en),
    .cfg_blk_len      (cfg_blk_len),
    .cfg_gap_len      (cfg_gap_len),
    .cfg_blks_per_sync(cfg_blks_per_sync),
    .cfg_lo_addr      (cfg_lo_addr),
    .cfg_hi_addr      (cfg_hi_addr),
    .cfg_bsn_init     (cfg_bsn_init),
    .iss_flags        (iss_flags),
    .iss_addr         (iss_addr),
    .iss_bsn          (iss_bsn)
  );

  bpg_pattern_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en  (iss_flags.valid),
    .rd_addr(iss_addr),
    .rd_data(out_data)
  );

  bpg_align #(.BSN_W(BSN_W)) u_align (
    .clk      (clk),
    .rst      (rst),
    .in_flags (iss_flags),
    .in_bsn   (iss_bsn),
    .out_flags(o_flags),
    .out_bsn  (out_bsn)
  );

  assign out_valid = o_flags.valid;
  assign out_sop   = o_flags.sop;
  assign out_eop   = o_flags.eop;
  assign out_sync  = o_flags.sync;

  // R3
  sop_in_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> out_valid);

  // R3
  eop_in_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_eop |-> out_valid);

  // R6
  sync_on_sop_chk: assert property (@(posedge clk) disable iff (rst)
    out_sync |-> out_sop);

  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sop) |-> $past(out_valid));
endmodule

// File: tb/test_blk_pattern_gen.sv
module test_blk_pattern_gen;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam int LEN_W  = 16;
  localparam int SYNC_W = 16;
  localparam int BSN_W  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_enable = 1'b0;
  logic              cfg_sync_en = 1'b0;
  logic [LEN_W-1:0]  cfg_blk_len = '0;
  logic [LEN_W-1:0]  cfg_gap_len = '0;
  logic [SYNC_W-1:0] cfg_blks_per_sync = '0;
  logic [ADDR_W-1:0] cfg_lo_addr = '0;
  logic [ADDR_W-1:0] cfg_hi_addr = '0;
  logic [BSN_W-1:0]  cfg_bsn_init = '0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] out_data;
  logic              out_valid, out_sop, out_eop, out_sync;
  logic [BSN_W-1:0]  out_bsn;

  logic [DATA_W-1:0] mem_m [1 << ADDR_W];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  blk_pattern_gen #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SYNC_W(SYNC_W), .BSN_W(BSN_W)
  ) i_blk_pattern_gen (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_sync_en(cfg_sync_en),
    .cfg_blk_len(cfg_blk_len), .cfg_gap_len(cfg_gap_len),
    .cfg_blks_per_sync(cfg_blks_per_sync), .cfg_lo_addr(cfg_lo_addr),
    .cfg_hi_addr(cfg_hi_addr), .cfg_bsn_init(cfg_bsn_init),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_sync(out_sync), .out_bsn(out_bsn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic mem_write(input int a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d; mem_m[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Expected output at cycle n after the first sample, from the block/gap cadence.
  task automatic run(input int len, input int gap, input int lo, input int hi, input int per,
                     input bit sen, input logic [BSN_W-1:0] init, input int nb, input string dtag);
    int p;
    p = len + gap;
    cfg_blk_len = LEN_W'(len); cfg_gap_len = LEN_W'(gap);
    cfg_lo_addr = ADDR_W'(lo); cfg_hi_addr = ADDR_W'(hi);
    cfg_blks_per_sync = SYNC_W'(per); cfg_sync_en = sen; cfg_bsn_init = init;
    repeat (3) @(negedge clk);
    cfg_enable = 1'b1;
    @(posedge clk);
    for (int n = 0; n < nb * p + 4; n++) begin
      int blk, pos, eaddr;
      bit ev, esop, eeop, esync;
      logic [BSN_W-1:0] ebsn;
      string vtag;
      @(posedge clk);
      @(negedge clk);
      blk   = n / p;
      pos   = n % p;
      ev    = (blk < nb) && (pos < len);
      esop  = ev && (pos == 0);
      eeop  = ev && (pos == len - 1);
      esync = esop && sen && ((blk % per) == 0);
      eaddr = lo + (pos % (hi - lo + 1));
      ebsn  = init + BSN_W'(blk);
      vtag  = (n == 0) ? "R2" : ((blk >= nb) ? "R8" : "R5");
      check(out_valid == ev, vtag, "valid", 64'(out_valid), 64'(ev));
      check(out_sop == esop, "R3", "sop", 64'(out_sop), 64'(esop));
      check(out_eop == eeop, "R3", "eop", 64'(out_eop), 64'(eeop));
      check(out_sync == esync, "R6", "sync", 64'(out_sync), 64'(esync));
      if (ev) begin
        check(out_data == mem_m[eaddr], dtag, "data", 64'(out_data), 64'(mem_m[eaddr]));
        check(out_bsn == ebsn, (blk == 0) ? "R8" : "R7", "bsn", 64'(out_bsn), 64'(ebsn));
      end
      if (n == (nb - 1) * p) cfg_enable = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7719));
    for (int a = 0; a < (1 << ADDR_W); a++) mem_m[a] = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0 && out_sop == 1'b0 && out_eop == 1'b0 && out_sync == 1'b0,
          "R1", "flags in reset", {60'd0, out_valid, out_sop, out_eop, out_sync}, 64'd0);
    rst = 1'b0;
    // zero the memory through the write port, then load the two-polarisation pattern
    for (int a = 0; a < (1 << ADDR_W); a++) mem_write(a, '0);
    for (int a = 0; a < 176; a++) mem_write(a, (a % 2 == 0) ? 16'h0101 : 16'hFFFF);
    // R1: idle while enable low
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(!out_valid && !out_sop && !out_eop && !out_sync, "R1", "idle flags",
            {60'd0, out_valid, out_sop, out_eop, out_sync}, 64'd0);
    end
    // Default cadence: 176 samples, 80 idle, 256-cycle period
    run(176, 80, 0, 175, 10, 1'b0, 32'd0, 3, "R4");
    // Sync every third block, sequence number wrap
    run(5, 3, 2, 9, 3, 1'b1, 32'hFFFF_FFFE, 7, "R4");
    // Address wrap inside a block, back-to-back blocks, sync each block
    run(9, 0, 10, 13, 1, 1'b1, 32'd100, 3, "R4");
    // Single-sample blocks
    run(1, 2, 5, 5, 2, 1'b1, 32'd7, 4, "R3");
    // R9: rewritten words are played out
    mem_write(40, 16'hA5C3); mem_write(41, 16'h1234); mem_write(42, 16'h8001); mem_write(43, 16'h7FFE);
    run(4, 2, 40, 43, 2, 1'b0, 32'd55, 2, "R9");
    // Constrained random runs
    for (int r = 0; r < 10; r++) begin
      int len, gap, lo, hi, per, nb;
      bit sen;
      logic [BSN_W-1:0] init;
      len  = 1 + int'($urandom_range(0, 19));
      gap  = int'($urandom_range(0, 10));
      if (len + gap < 2) gap = 1;
      lo   = int'($urandom_range(0, 199));
      hi   = lo + int'($urandom_range(0, 30));
      per  = 1 + int'($urandom_range(0, 4));
      sen  = bit'($urandom_range(0, 1));
      init = $urandom;
      nb   = 1 + int'($urandom_range(0, 5));
      if (r % 3 == 0) begin
        for (int k = 0; k < 4; k++) mem_write(lo + k, DATA_W'($urandom));
        run(len, gap, lo, hi, per, sen, init, nb, "R9");
      end else begin
        run(len, gap, lo, hi, per, sen, init, nb, "R4");
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule